// File: doc/BRIEF.md
# Key-Protected Oscillator Configuration Register Bank

This block is a bank of 32-bit registers on a simple word-wide register bus. It holds one configuration word for each of a set of external clock generators, five by default. The words leave the block on a flat output bus. A guard register keeps the configuration words read-only until software writes a 16-bit key to it. Any other value written to the guard closes it again.

Each configuration word has a companion reload word. Software can write the reload words at any time, with no key. A warm (manual) reset copies every reload word into its configuration word and closes the guard, so settings that software chose survive that reset. A cold (power-on) reset puts one fixed default value into both sets. Reads come back on the bus one clock after the read request.

Top module: `clkcfg_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration word and every reload word takes the default value (0x0002C00F by default), the guard closes, and the stored key field clears. A read of the guard at offset 0x20 therefore returns 0x00010000.
- R2: A full-word write to a configuration word (offsets 0x0C, 0x10, 0x14, 0x18, 0x1C for slots 0 to 4) while the guard is closed leaves that word unchanged.
- R3: A full-word write to offset 0x20 whose bits [15:0] equal 0xA05F opens the guard. While the guard is open, full-word writes to configuration words take effect at the next clock edge.
- R4: A full-word write to offset 0x20 with any other value in bits [15:0] closes the guard. A read of offset 0x20 returns bits [15:0] as last written, with bit 16 set to 1 when closed and 0 when open, and zeros above bit 16.
- R5: Reload words at offsets 0x8C, 0x90, 0x94, 0x98, 0x9C (slots 0 to 4) accept full-word writes whether the guard is open or closed, and read back what was written.
- R6: While `warm_rst_n` is low (and `rst_n` high) at a clock edge, each configuration word takes the value its reload word held before that edge. The guard closes, the key field clears, and the reload words are not changed by the reset itself.
- R7: A write with any bit of `wstrb` low has no effect on any register, including the guard.
- R8: A read presented with `rd_en` returns its data on `rdata` after the next clock edge, and `rdata` holds otherwise. Offsets that are not word-aligned or not listed above read as zero.
- R9: When a warm reset and a bus write fall in the same cycle, a write to a reload word is still taken, and its configuration word receives the previous reload value. Writes to configuration words and to the guard in that cycle are dropped.
- R10: `osc_cfg` carries configuration slot i in bits [32*i+31:32*i] and shows each register's value from the clock edge that loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| addr | input | 12 | Byte offset within the bank |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte strobes; only all-ones writes are honoured |
| rdata | output | 32 | Registered read data |
| osc_cfg | output | 160 | Configuration words, slot 0 in the low bits |

## Verification
A warm reset and a bus write can land in the same cycle. The bench does this in two ways. It pulses `warm_rst_n` for one cycle while writing a new value to reload slot 0. It then pulses it again while writing a configuration word with the guard open. In each case it reads back the configuration word, the reload word and the guard. The first word must carry the pre-write reload value, the reload word the new data, and the guard must be closed with the dropped write absent. A behavioural model that applies the reset copy before the reload write also compares `osc_cfg` and `rdata` on every clock.

// File: rtl/clkcfg_pkg.sv
// Shared constants and decode types for the oscillator configuration bank.
// Assumes at most 16 configuration slots (index field width below).
package clkcfg_pkg;

    localparam int unsigned KEY_W = 16;
    localparam int unsigned IDX_W = 4;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_CFG  = 2'd1,
        HIT_SHD  = 2'd2,
        HIT_LOCK = 2'd3
    } hit_kind_e;

    typedef struct packed {
        hit_kind_e         kind;
        logic [IDX_W-1:0]  idx;
    } hit_t;

endpackage

// File: rtl/clkcfg_decode.sv
// Address decoder: maps a byte offset to the register class and slot index.
// Assumes word-aligned offsets; any offset with low bits set is undecoded.
module clkcfg_decode
    import clkcfg_pkg::*;
#(
    parameter int unsigned AW       = 12,
    parameter int unsigned N_OSC    = 5,
    parameter int unsigned CFG_OFF  = 'h00C,
    parameter int unsigned SHD_OFF  = 'h08C,
    parameter int unsigned LOCK_OFF = 'h020
) (
    input  logic [AW-1:0] addr,
    output hit_t          hit
);
    localparam int CFG_W0  = int'(CFG_OFF / 4);
    localparam int SHD_W0  = int'(SHD_OFF / 4);
    localparam int LOCK_W0 = int'(LOCK_OFF / 4);

    logic [AW-3:0] word;
    logic          aligned;
    int            w;

    assign word    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign w       = int'(word);

    // Classify the offset into configuration, reload, guard or nothing.
    always_comb begin
        hit.kind = HIT_NONE;
        hit.idx  = '0;
        if (aligned) begin
            if (w >= CFG_W0 && w < CFG_W0 + int'(N_OSC)) begin
                hit.kind = HIT_CFG;
                hit.idx  = IDX_W'(w - CFG_W0);
            end else if (w >= SHD_W0 && w < SHD_W0 + int'(N_OSC)) begin
                hit.kind = HIT_SHD;
                hit.idx  = IDX_W'(w - SHD_W0);
            end else if (w == LOCK_W0) begin
                hit.kind = HIT_LOCK;
            end
        end
    end
endmodule

// File: rtl/clkcfg_lock.sv
// Write guard for the configuration words. Opens on the key, closes on any
// other value, and closes on either reset. Keeps the last key field written.
// Assumes wr_ok is already qualified by full strobes and the warm reset.
module clkcfg_lock
    import clkcfg_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst_n,
    input  logic             wr_ok,
    input  logic [KEY_W-1:0] wkey,
    output logic             locked,
    output logic [KEY_W-1:0] key_last
);
    // Guard state and stored key field; both resets close the guard.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n) begin
            locked   <= 1'b1;
            key_last <= '0;
        end else if (wr_ok) begin
            locked   <= (wkey != KEY);
            key_last <= wkey;
        end
    end
endmodule

// File: rtl/clkcfg_slot.sv
// One oscillator slot: a configuration word and its reload word.
// Cold reset loads the default into both; warm reset copies reload into
// configuration while the reload word still accepts a write that cycle.
module clkcfg_slot #(
    parameter int unsigned DW          = 32,
    parameter logic [DW-1:0] DEFAULT_V = 32'h0002_C00F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst_n,
    input  logic          cfg_we,
    input  logic          shd_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] shd_q
);
    // Configuration word: default, reload copy, or guarded write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= DEFAULT_V;
        else if (!warm_rst_n)
            cfg_q <= shd_q;
        else if (cfg_we)
            cfg_q <= wdata;
    end

    // Reload word: default on cold reset only, otherwise free write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shd_q <= DEFAULT_V;
        else if (shd_we)
            shd_q <= wdata;
    end
endmodule

// File: rtl/clkcfg_rdmux.sv
// Read multiplexer: selects the word addressed by the decoded hit.
// Undecoded offsets yield zero.
module clkcfg_rdmux
    import clkcfg_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned N_OSC = 5
) (
    input  hit_t                     hit,
    input  logic [N_OSC-1:0][DW-1:0] cfg_words,
    input  logic [N_OSC-1:0][DW-1:0] shd_words,
    input  logic [DW-1:0]            lock_word,
    output logic [DW-1:0]            rd_word
);
    // Pick the source word for the current read.
    always_comb begin
        rd_word = '0;
        unique case (hit.kind)
            HIT_CFG:  rd_word = cfg_words[hit.idx];
            HIT_SHD:  rd_word = shd_words[hit.idx];
            HIT_LOCK: rd_word = lock_word;
            default:  rd_word = '0;
        endcase
    end
endmodule

// File: rtl/clkcfg_bank.sv
// Top of the key-protected oscillator configuration bank. Decodes the bus,
// qualifies writes (full strobes, guard, warm reset), instantiates one slot
// per oscillator and registers read data. Assumes single-cycle bus requests.
module clkcfg_bank
    import clkcfg_pkg::*;
#(
    parameter int unsigned AW          = 12,
    parameter int unsigned DW          = 32,
    parameter int unsigned N_OSC       = 5,
    parameter int unsigned CFG_OFF     = 'h00C,
    parameter int unsigned SHD_OFF     = 'h08C,
    parameter int unsigned LOCK_OFF    = 'h020,
    parameter logic [KEY_W-1:0] KEY    = 16'hA05F,
    parameter logic [DW-1:0] DEFAULT_V = 32'h0002_C00F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                warm_rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic [DW/8-1:0]     wstrb,
    output logic [DW-1:0]       rdata,
    output logic [N_OSC*DW-1:0] osc_cfg
);
    localparam int unsigned PAD_W = DW - KEY_W - 1;

    hit_t                     hit;
    logic                     full_wr;
    logic                     bus_wr_ok;
    logic                     locked;
    logic [KEY_W-1:0]         key_last;
    logic [DW-1:0]            lock_word;
    logic [DW-1:0]            rd_word;
    logic [N_OSC-1:0][DW-1:0] cfg_words;
    logic [N_OSC-1:0][DW-1:0] shd_words;
    logic [N_OSC*DW-1:0]      shd_flat;

    clkcfg_decode #(
        .AW(AW), .N_OSC(N_OSC), .CFG_OFF(CFG_OFF),
        .SHD_OFF(SHD_OFF), .LOCK_OFF(LOCK_OFF)
    ) u_decode (
        .addr (addr),
        .hit  (hit)
    );

    // Write qualification: all strobes set; warm reset blocks guarded paths.
    assign full_wr   = wr_en && (&wstrb);
    assign bus_wr_ok = full_wr && warm_rst_n;

    clkcfg_lock #(.KEY(KEY)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_rst_n (warm_rst_n),
        .wr_ok      (bus_wr_ok && (hit.kind == HIT_LOCK)),
        .wkey       (wdata[KEY_W-1:0]),
        .locked     (locked),
        .key_last   (key_last)
    );

    assign lock_word = {{PAD_W{1'b0}}, locked, key_last};

    for (genvar i = 0; i < N_OSC; i++) begin : g_slot
        logic cfg_we_i;
        logic shd_we_i;

        // Per-slot write enables from the decoded index.
        assign cfg_we_i = bus_wr_ok && !locked && (hit.kind == HIT_CFG)
                          && (hit.idx == IDX_W'(i));
        assign shd_we_i = full_wr && (hit.kind == HIT_SHD)
                          && (hit.idx == IDX_W'(i));

        clkcfg_slot #(.DW(DW), .DEFAULT_V(DEFAULT_V)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .warm_rst_n (warm_rst_n),
            .cfg_we     (cfg_we_i),
            .shd_we     (shd_we_i),
            .wdata      (wdata),
            .cfg_q      (cfg_words[i]),
            .shd_q      (shd_words[i])
        );

        assign osc_cfg[i*DW +: DW]  = cfg_words[i];
        assign shd_flat[i*DW +: DW] = shd_words[i];
    end

    clkcfg_rdmux #(.DW(DW), .N_OSC(N_OSC)) u_rdmux (
        .hit       (hit),
        .cfg_words (cfg_words),
        .shd_words (shd_words),
        .lock_word (lock_word),
        .rd_word   (rd_word)
    );

    // Registered read data, updated only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_word;
    end
endmodule

// File: rtl/clkcfg_bank_chk.sv
// Property checker for clkcfg_bank, attached by bind. Recomputes address
// classes from the bus and watches the configuration, reload and guard state.
module clkcfg_bank_chk #(
    parameter int unsigned AW       = 12,
    parameter int unsigned DW       = 32,
    parameter int unsigned N_OSC    = 5,
    parameter int unsigned CFG_OFF  = 'h00C,
    parameter int unsigned LOCK_OFF = 'h020,
    parameter logic [15:0] KEY      = 16'hA05F,
    parameter logic [DW-1:0] DEFAULT_V = 32'h0002_C00F
) (
    input logic                clk,
    input logic                rst_n,
    input logic                warm_rst_n,
    input logic                wr_en,
    input logic [AW-1:0]       addr,
    input logic [DW-1:0]       wdata,
    input logic [DW/8-1:0]     wstrb,
    input logic [N_OSC*DW-1:0] osc_cfg,
    input logic [N_OSC*DW-1:0] shd_flat,
    input logic                locked
);
    localparam int CFG_LO = int'(CFG_OFF);
    localparam int CFG_HI = int'(CFG_OFF) + 4 * int'(N_OSC);

    logic cfg_hit;
    logic lock_hit;
    logic full_wr;

    assign cfg_hit  = (addr[1:0] == 2'b00) && (int'(addr) >= CFG_LO)
                      && (int'(addr) < CFG_HI);
    assign lock_hit = (int'(addr) == int'(LOCK_OFF));
    assign full_wr  = wr_en && (&wstrb);

    AST_COLD_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (osc_cfg == {N_OSC{DEFAULT_V}}) && locked); // R1

    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && cfg_hit && locked && warm_rst_n) |=> $stable(osc_cfg)); // R2

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && lock_hit && warm_rst_n && wdata[15:0] == KEY) |=> !locked); // R3

    AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && lock_hit && warm_rst_n && wdata[15:0] != KEY) |=> locked); // R4

    AST_WARM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> (osc_cfg == $past(shd_flat))); // R6

    AST_WARM_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> locked); // R6

    AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(&wstrb) && warm_rst_n)
        |=> $stable(osc_cfg) && $stable(shd_flat) && $stable(locked)); // R7
endmodule

bind clkcfg_bank clkcfg_bank_chk #(
    .AW(AW), .DW(DW), .N_OSC(N_OSC), .CFG_OFF(CFG_OFF),
    .LOCK_OFF(LOCK_OFF), .KEY(KEY), .DEFAULT_V(DEFAULT_V)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_n (warm_rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .wstrb      (wstrb),
    .osc_cfg    (osc_cfg),
    .shd_flat   (shd_flat),
    .locked     (locked)
);

// File: tb/tb_clkcfg_bank.sv
// Bench for clkcfg_bank: directed bus sequences, a behavioural model
// compared on every clock, and explicit read-back checks per requirement.
module tb_clkcfg_bank;
    localparam int N = 5;
    localparam logic [31:0] DEF = 32'h0002_C00F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = 4'hF;
    logic [31:0] rdata;
    logic [N*32-1:0] osc_cfg;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    string tag = "R1";
    bit    done = 0;

    logic [31:0] m_cfg [N];
    logic [31:0] m_shd [N];
    logic        m_locked;
    logic [15:0] m_key;
    logic [31:0] m_rdata;

    clkcfg_bank dut (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .wstrb(wstrb), .rdata(rdata), .osc_cfg(osc_cfg)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int w;
        w = int'(a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (w >= 'h0C && w < 'h0C + 4*N) return m_cfg[(w - 'h0C) / 4];
        if (w >= 'h8C && w < 'h8C + 4*N) return m_shd[(w - 'h8C) / 4];
        if (w == 'h20) return {15'h0, m_locked, m_key};
        return 32'h0;
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        logic [31:0] rv;
        logic        full;
        int          w;
        cyc++;
        rv   = m_read(addr);
        full = wr_en && (wstrb == 4'hF);
        w    = int'(addr);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_cfg[i] = DEF; m_shd[i] = DEF; end
            m_locked = 1'b1; m_key = '0; m_rdata = '0;
        end else begin
            if (rd_en) m_rdata = rv;
            if (!warm_rst_n) begin
                for (int i = 0; i < N; i++) m_cfg[i] = m_shd[i];
                m_locked = 1'b1; m_key = '0;
                if (full && addr[1:0] == 0 && w >= 'h8C && w < 'h8C + 4*N)
                    m_shd[(w - 'h8C) / 4] = wdata;
            end else if (full && addr[1:0] == 0) begin
                if (w >= 'h0C && w < 'h0C + 4*N && !m_locked)
                    m_cfg[(w - 'h0C) / 4] = wdata;
                else if (w >= 'h8C && w < 'h8C + 4*N)
                    m_shd[(w - 'h8C) / 4] = wdata;
                else if (w == 'h20) begin
                    m_key = wdata[15:0];
                    m_locked = (wdata[15:0] != 16'hA05F);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Model comparison on every falling edge (R10 output slots, R8 read data).
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            for (int i = 0; i < N; i++)
                check({tag, "/R10 osc_cfg"}, osc_cfg[i*32 +: 32], m_cfg[i]);
            check({tag, "/R8 rdata"}, rdata, m_rdata);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        wr_en = 1'b0; wstrb = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 cold reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd('h00C, DEF, "R1 cfg0 default");
        rd('h09C, DEF, "R1 reload4 default");
        rd('h020, 32'h0001_0000, "R1 guard closed");

        // R2 write while closed is dropped
        tag = "R2";
        wr('h014, 32'hDEAD_0002);
        rd('h014, DEF, "R2 cfg2 unchanged");

        // R3 key opens, writes land
        tag = "R3";
        wr('h020, 32'h0000_A05F);
        rd('h020, 32'h0000_A05F, "R3 guard open");
        for (int i = 0; i < N; i++) wr(12'('h0C + 4*i), 32'h1100_0000 + i);
        rd('h018, 32'h1100_0003, "R3 cfg3 written");

        // R4 other value closes, key field read back
        tag = "R4";
        wr('h020, 32'h1234_0001);
        rd('h020, 32'h0001_0001, "R4 guard closed with key field");
        wr('h010, 32'h2222_2222);
        rd('h010, 32'h1100_0001, "R4 cfg1 write dropped");

        // R5 reload words free
        tag = "R5";
        for (int i = 0; i < N; i++) wr(12'('h8C + 4*i), 32'h3300_0000 + i);
        rd('h094, 32'h3300_0002, "R5 reload2 written while closed");

        // R7 partial strobes ignored
        tag = "R7";
        wr('h020, 32'h0000_A05F);
        wr('h018, 32'h4444_4444, 4'b0111);
        rd('h018, 32'h1100_0003, "R7 cfg3 partial write ignored");
        wr('h020, 32'h0000_0000, 4'b1110);
        rd('h020, 32'h0000_A05F, "R7 guard partial write ignored");
        wr('h090, 32'h0000_0055, 4'b0001);
        rd('h090, 32'h3300_0001, "R7 reload1 partial write ignored");

        // R8 undecoded reads
        tag = "R8";
        rd('h000, 32'h0, "R8 offset 0x000 zero");
        rd('h024, 32'h0, "R8 offset 0x024 zero");
        rd('h0A0, 32'h0, "R8 offset 0x0A0 zero");
        rd('h00E, 32'h0, "R8 misaligned zero");

        // R9 / R6 warm reset with a simultaneous reload write
        tag = "R9";
        @(negedge clk);
        warm_rst_n = 1'b0; wr_en = 1'b1; addr = 'h08C; wdata = 32'h6666_6666;
        @(negedge clk);
        warm_rst_n = 1'b1; wr_en = 1'b0;
        check("R10 port slot0 after warm", osc_cfg[31:0], 32'h3300_0000);
        rd('h00C, 32'h3300_0000, "R9 cfg0 got old reload");
        rd('h08C, 32'h6666_6666, "R9 reload0 took write");
        tag = "R6";
        rd('h01C, 32'h3300_0004, "R6 cfg4 reloaded");
        rd('h098, 32'h3300_0003, "R6 reload3 unchanged");
        rd('h020, 32'h0001_0000, "R6 guard closed");

        // R9 configuration write during warm reset dropped
        tag = "R9";
        wr('h020, 32'h0000_A05F);
        @(negedge clk);
        warm_rst_n = 1'b0; wr_en = 1'b1; addr = 'h014; wdata = 32'h7777_7777;
        @(negedge clk);
        warm_rst_n = 1'b1; wr_en = 1'b0;
        rd('h014, 32'h3300_0002, "R9 cfg2 write dropped in warm reset");
        rd('h020, 32'h0001_0000, "R9 guard closed after warm reset");

        // R1 cold reset again
        tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 port slot0 after cold reset", osc_cfg[31:0], DEF);
        rd('h08C, DEF, "R1 reload0 back to default");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule